// File: doc/BRIEF.md
# Concealed-Key Privilege Escalation Decoder

This block sits in the decode stage of a 32-bit RISC-V style core and looks at one instruction at a time. Words whose low seven bits carry the custom-0 major opcode (0001011) are treated as U-type. Such a word decodes as valid only when its 20-bit upper-immediate field equals a concealed key. Any other custom-0 word is reported as an invalid instruction. Words with any other opcode pass through with no report and no effect, because other decoders handle them.

A word that matches the key never raises an exception. When it arrives while the core is in user mode and the x10 operand equals a second concealed value, the block asks for the privilege level to be written to machine mode. In every other case the matching word completes silently and has no effect. Both concealed values are parameters of the block.

The instruction stream enters on a valid/ready handshake. The result leaves through a single output register, also on a valid/ready handshake. Back-pressure works as follows. The input is accepted only when the output register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the result stays frozen. The x10 value and the current privilege are sampled together with the instruction in its accept cycle. A result appears on the output one cycle after it is accepted.

Top module: `hidden_key_decoder`

## Requirements
- R1: A word with bits 6:0 = 7'b0001011 and bits 31:12 equal to parameter KEY produces a result with `illegal` low.
- R2: A word with bits 6:0 = 7'b0001011 and bits 31:12 not equal to KEY produces a result with `illegal` high, `cause` equal to parameter ILL_CAUSE (default 2), and `priv_we` low.
- R3: A word whose bits 6:0 differ from 7'b0001011 produces a result with `illegal` low, `cause` zero and `priv_we` low, whatever its other bits are.
- R4: A key-matching word, accepted while `cur_priv` = 2'b00 (user) and `x10_val` equals parameter X10_SECRET in all 32 bits, produces `priv_we` high with `priv_new` = 2'b11 (machine).
- R5: A key-matching word accepted with any other `x10_val` produces `illegal` low and `priv_we` low.
- R6: A key-matching word accepted while `cur_priv` is not 2'b00 (for example 2'b01 or 2'b11) produces `priv_we` low, even when `x10_val` is correct.
- R7: `priv_we` is high only in a cycle where `out_valid` and `out_ready` are both high, so each granting result pulses it exactly once.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `illegal`, `cause` and `priv_new` hold their values.
- R9: During and right after reset, `out_valid`, `illegal` and `priv_we` are low and `in_ready` is high.
- R10: Bits 11:7 of the word (the destination field) do not affect whether the word matches the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block can take the offered word |
| instr | input | 32 | Fetched instruction word |
| x10_val | input | 32 | Value of register x10 at the instruction |
| cur_priv | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| out_valid | output | 1 | Decode result present |
| out_ready | input | 1 | Consumer takes the result |
| illegal | output | 1 | Invalid-instruction exception requested |
| cause | output | 4 | Exception cause code while `illegal` is high, else zero |
| priv_we | output | 1 | One-cycle privilege write enable |
| priv_new | output | 2 | Privilege to write (machine when granting) |

## Verification
The bench builds the block with KEY = 0x0C3A5 and X10_SECRET = 0x7E21, which differ from the defaults. A key hard-wired into the logic would therefore be caught. The chosen values let the bench place near-misses right beside the secrets: keys one bit off, including one with a set bit above bit 15, and x10 values off by one or carrying an extra upper bit. It also toggles the destination field and holds the output under back-pressure while new words wait at the input.

// File: rtl/hkd_pkg.sv
package hkd_pkg;
  localparam int unsigned OPC_W = 7;
  localparam logic [OPC_W-1:0] OPC_CUSTOM0 = 7'b0001011;
  localparam logic [1:0] PRIV_USER = 2'b00;
  localparam logic [1:0] PRIV_MACH = 2'b11;

  typedef struct packed {
    logic       bad_key;
    logic       grant;
    logic [1:0] priv;
  } hkd_result_t;
endpackage

// File: rtl/hk_match.sv
module hk_match
  import hkd_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned KEY_W = XLEN - 12,
  parameter logic [KEY_W-1:0] KEY = '0
) (
  input  logic [XLEN-1:0] instr,
  output logic            is_custom,
  output logic            key_hit
);
  localparam int unsigned RD_W = XLEN - KEY_W - OPC_W;
  localparam logic [XLEN-1:0] PATTERN  = {KEY, {RD_W{1'b0}}, OPC_CUSTOM0};
  localparam logic [XLEN-1:0] CMP_MASK = {{KEY_W{1'b1}}, {RD_W{1'b0}}, {OPC_W{1'b1}}};

  always_comb begin
    is_custom = (instr[OPC_W-1:0] == OPC_CUSTOM0);
    key_hit   = (((instr ^ PATTERN) & CMP_MASK) == '0);
  end
endmodule

// File: rtl/hk_grant.sv
module hk_grant
  import hkd_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] X10_SECRET = '0
) (
  input  logic            key_hit,
  input  logic [XLEN-1:0] x10_val,
  input  logic [1:0]      cur_priv,
  output logic            grant
);
  always_comb begin
    grant = key_hit && (x10_val == X10_SECRET) && (cur_priv == PRIV_USER);
  end
endmodule

// File: rtl/hk_stage.sv
module hk_stage
  import hkd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  hkd_result_t d,
  output logic        out_valid,
  input  logic        out_ready,
  output hkd_result_t q
);
  logic vld_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      q     <= '0;
    end else if (in_valid && in_ready) begin
      vld_q <= 1'b1;
      q     <= d;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q)));
  assert_stalled_input_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> out_valid);
endmodule

// File: rtl/hidden_key_decoder.sv
module hidden_key_decoder
  import hkd_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-13:0] KEY = 20'h05A3C,
  parameter logic [XLEN-1:0] X10_SECRET = 32'h00001D7B,
  parameter int unsigned CAUSE_W = 4,
  parameter logic [CAUSE_W-1:0] ILL_CAUSE = 4'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [XLEN-1:0]    instr,
  input  logic [XLEN-1:0]    x10_val,
  input  logic [1:0]         cur_priv,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               illegal,
  output logic [CAUSE_W-1:0] cause,
  output logic               priv_we,
  output logic [1:0]         priv_new
);
  localparam int unsigned KEY_W = XLEN - 12;

  logic        is_custom, key_hit, grant;
  hkd_result_t res_d, res_q;

  hk_match #(.XLEN(XLEN), .KEY_W(KEY_W), .KEY(KEY)) u_match (
    .instr(instr), .is_custom(is_custom), .key_hit(key_hit)
  );

  hk_grant #(.XLEN(XLEN), .X10_SECRET(X10_SECRET)) u_grant (
    .key_hit(key_hit), .x10_val(x10_val), .cur_priv(cur_priv), .grant(grant)
  );

  always_comb begin
    res_d.bad_key = is_custom && !key_hit;
    res_d.grant   = grant;
    res_d.priv    = grant ? PRIV_MACH : cur_priv;
  end

  hk_stage u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d(res_d), .out_valid(out_valid), .out_ready(out_ready), .q(res_q)
  );

  always_comb begin
    illegal  = out_valid && res_q.bad_key;
    cause    = illegal ? ILL_CAUSE : '0;
    priv_we  = out_valid && out_ready && res_q.grant;
    priv_new = res_q.priv;
  end

  assert_illegal_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (cause == ILL_CAUSE && !priv_we));
  assert_grant_to_machine_R4: assert property (@(posedge clk) disable iff (!rst_n)
    priv_we |-> (priv_new == PRIV_MACH && !illegal));
  assert_we_only_on_transfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    priv_we |-> (out_valid && out_ready));
  assert_quiet_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!illegal && !priv_we && in_ready));
endmodule

// File: tb/hidden_key_decoder_bench.sv
module hidden_key_decoder_bench;
  localparam logic [19:0] TB_KEY = 20'h0C3A5;
  localparam logic [31:0] TB_SEC = 32'h00007E21;
  localparam logic [6:0]  C0     = 7'b0001011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] instr = '0, x10_val = '0;
  logic [1:0]  cur_priv = 2'b00;
  logic        in_ready, out_valid, illegal, priv_we;
  logic [3:0]  cause;
  logic [1:0]  priv_new;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural model state
  bit       m_v = 0, m_ill = 0, m_gr = 0;
  bit [1:0] m_pr = 0;
  string    m_tag = "R9";

  always #10 clk = ~clk;

  hidden_key_decoder #(.KEY(TB_KEY), .X10_SECRET(TB_SEC)) u_hidden_key_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .x10_val(x10_val), .cur_priv(cur_priv),
    .out_valid(out_valid), .out_ready(out_ready), .illegal(illegal),
    .cause(cause), .priv_we(priv_we), .priv_new(priv_new)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // drive one cycle: set inputs, compare against model, advance model
  task automatic step(input bit v, input logic [31:0] w, input logic [31:0] x,
                      input logic [1:0] p, input bit rdy, input string tag);
    bit exp_rdy, acc, xfer, exp_we;
    in_valid = v; instr = w; x10_val = x; cur_priv = p; out_ready = rdy;
    #1;
    exp_rdy = !m_v || rdy;
    exp_we  = m_v && rdy && m_gr;
    check(in_ready == exp_rdy, "R8", "in_ready", in_ready, exp_rdy);
    check(out_valid == m_v, "R8", "out_valid", out_valid, m_v);
    check(priv_we == exp_we, m_gr ? "R7" : m_tag, "priv_we", priv_we, exp_we);
    if (m_v) begin
      check(illegal == m_ill, m_tag, "illegal", illegal, m_ill);
      check(cause == (m_ill ? 4'd2 : 4'd0), m_tag, "cause", cause, m_ill ? 4'd2 : 4'd0);
      check(priv_new == m_pr, m_gr ? "R4" : m_tag, "priv_new", priv_new, m_pr);
    end else begin
      check(illegal == 1'b0 && priv_we == 1'b0, "R9", "idle outputs", {illegal, priv_we}, 0);
    end
    acc  = v && exp_rdy;
    xfer = m_v && rdy;
    if (acc) begin
      m_v   = 1;
      m_ill = (w[6:0] == C0) && (w[31:12] != TB_KEY);
      m_gr  = (w[6:0] == C0) && (w[31:12] == TB_KEY) && (x == TB_SEC) && (p == 2'b00);
      m_pr  = m_gr ? 2'b11 : p;
      m_tag = tag;
    end else if (xfer) begin
      m_v = 0;
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] enc(input logic [19:0] k, input logic [4:0] rd);
    return {k, rd, C0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WATCHDOG", "timeout", 0, 1);
    summary();
  end

  initial begin
    @(negedge clk);
    // reset state: R9
    repeat (2) begin
      #1;
      check(out_valid == 0 && illegal == 0 && priv_we == 0, "R9", "reset outputs",
            {out_valid, illegal, priv_we}, 0);
      @(negedge clk);
    end
    rst_n = 1;
    step(0, 0, 0, 2'b00, 1, "R9");
    // R4 grant from user with correct x10
    step(1, enc(TB_KEY, 5'd0), TB_SEC, 2'b00, 1, "R4");
    step(0, 0, 0, 2'b00, 1, "R4");
    // R5 wrong x10 values
    step(1, enc(TB_KEY, 5'd0), TB_SEC + 1, 2'b00, 1, "R5");
    step(1, enc(TB_KEY, 5'd3), TB_SEC | 32'h00010000, 2'b00, 1, "R5");
    step(1, enc(TB_KEY, 5'd0), 32'h0, 2'b00, 1, "R1");
    // R2 key mismatch, near misses
    step(1, enc(TB_KEY ^ 20'h00001, 5'd0), TB_SEC, 2'b00, 1, "R2");
    step(1, enc(TB_KEY | 20'h10000, 5'd0), TB_SEC, 2'b00, 1, "R2");
    step(1, enc(20'h00000, 5'd0), TB_SEC, 2'b00, 1, "R2");
    // R3 other opcodes, including key bits with a different opcode
    step(1, 32'h00000013, TB_SEC, 2'b00, 1, "R3");
    step(1, {TB_KEY, 5'd0, 7'b0001111}, TB_SEC, 2'b00, 1, "R3");
    step(1, {TB_KEY, 5'd0, 7'b0101011}, TB_SEC, 2'b00, 1, "R3");
    // R6 non-user privileges
    step(1, enc(TB_KEY, 5'd0), TB_SEC, 2'b11, 1, "R6");
    step(1, enc(TB_KEY, 5'd0), TB_SEC, 2'b01, 1, "R6");
    // R10 destination field varied
    step(1, enc(TB_KEY, 5'd31), TB_SEC, 2'b00, 1, "R10");
    step(1, enc(TB_KEY, 5'd10), TB_SEC, 2'b00, 1, "R10");
    step(1, enc(TB_KEY ^ 20'h00800, 5'd31), TB_SEC, 2'b00, 1, "R10");
    // R8 back-pressure: grant result held, input waits
    step(1, enc(TB_KEY, 5'd0), TB_SEC, 2'b00, 0, "R7");
    step(1, enc(20'h00001, 5'd0), TB_SEC, 2'b00, 0, "R8");
    step(1, enc(20'h00001, 5'd0), TB_SEC, 2'b00, 0, "R8");
    step(1, enc(20'h00001, 5'd0), TB_SEC, 2'b00, 1, "R2");
    step(0, 0, 0, 2'b00, 0, "R8");
    step(0, 0, 0, 2'b00, 1, "R8");
    // streaming mix with intermittent ready
    for (int i = 0; i < 40; i++) begin
      logic [19:0] k;
      logic [31:0] x;
      k = (i % 3 == 0) ? TB_KEY : TB_KEY ^ 20'(i);
      x = (i % 4 == 0) ? TB_SEC : TB_SEC ^ 32'(i);
      step(i % 5 != 4, enc(k, 5'(i)), x, (i % 7 == 0) ? 2'b11 : 2'b00,
           i % 3 != 1, "R7");
    end
    step(0, 0, 0, 2'b00, 1, "R8");
    step(0, 0, 0, 2'b00, 1, "R9");
    summary();
  end
endmodule